// File: doc/BRIEF.md
# Accumulator Machine Fetch-Execute Sequencer

This block is the control path and datapath of a small single-accumulator processor with 36-bit words and a 15-bit address field. Every instruction starts with a fetch that moves the program counter into an address register and from there into the memory address register. The word that memory returns is captured in a storage register, and its opcode is also captured in an operation register. The address field of the instruction is then routed back through the address register for the operand access. During the operand cycles the operation register keeps the opcode it already holds, so the data word never disturbs it.

Three operations exist. Load-accumulator clears the accumulator and then adds the operand into it. Add forms a sign-magnitude sum of the accumulator and the operand. Branch-while-busy jumps only while an external data channel reports that it is running. A program uses this branch to spin on itself until a transfer has finished. Any other opcode stops the sequencer. Program memory is an internal synchronous single-port array with a fixed read latency. It is loaded through a write port while the core is idle, and a start pulse launches execution at address 0.

Top module: `acm_seq`

## Requirements
- R1: After reset the accumulator, program counter, operation register, overflow flag and halt flag are all zero. The core does nothing until `start` is pulsed, and it then fetches from address 0.
- R2: Each instruction fetch copies the PC into the address register, then copies the address register into the memory address register, and adds exactly one to the PC.
- R3: Word layout: bits 35:24 are the opcode, bits 14:0 are the address field, and bits 23:15 are ignored. An instruction fetch loads the full word into the storage register and bits 35:24 into the operation register.
- R4: An operand fetch loads the storage register only. The operation register keeps the current opcode, even when the data word has nonzero bits 35:24.
- R5: Opcode 0x050 (load-accumulator) clears the accumulator, then fetches the addressed word and places it in the accumulator.
- R6: Opcode 0x040 (add) replaces the accumulator with the sign-magnitude sum of the accumulator and the operand. Bit 35 is the sign (1 = negative) and bits 34:0 are the magnitude. With unlike signs, the result takes the sign of the larger magnitude, and equal magnitudes give +0.
- R7: A carry out of the 35-bit magnitude drops the carry, keeps the truncated magnitude and sets an overflow flag. The flag stays set until reset.
- R8: Opcode 0x006 (branch-while-busy) loads the PC with the instruction's address field if `chan_busy` is high. Otherwise the PC keeps its incremented value.
- R9: Any other opcode stops the core with `halt_o` high. The PC then points one past that instruction and the operation register shows the opcode. This state lasts until reset, and `start` does not change it.
- R10: After each instruction completes, the next fetch begins at the current PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse that begins execution at address 0 |
| chan_busy | input | 1 | High while the data channel is transferring |
| ld_we | input | 1 | Program memory write enable (use while idle) |
| ld_addr | input | MEM_AW | Program memory write address |
| ld_data | input | WORD_W | Program memory write data |
| acc_o | output | WORD_W | Accumulator |
| pc_o | output | FLD_W | Program counter |
| opc_o | output | OPC_W | Operation register |
| mar_o | output | FLD_W | Memory address register |
| ovf_o | output | 1 | Sticky overflow flag |
| halt_o | output | 1 | High once the core has stopped on an unknown opcode |

## Verification
Sign handling in the add is the main corner. Cases with unlike signs and either magnitude larger, an exact cancellation, and a carry out of the top magnitude bit would show a design that takes the wrong sign, produces negative zero, or loses the overflow. A later add without carry after an overflow shows whether the flag is sticky or gets overwritten. Operands whose upper bits look like an opcode would show up as a changing operation register if the operand fetch wrote it. The busy branch is run both as a self-loop held by the channel and as a forward jump, and with the channel idle. A design that ignores the channel, keeps the old PC or jumps always would end at the wrong PC or with the wrong accumulator.

// File: rtl/acm_pkg.sv
package acm_pkg;
  localparam logic [11:0] OPC_LDACC = 12'h050;
  localparam logic [11:0] OPC_ADD   = 12'h040;
  localparam logic [11:0] OPC_BBUSY = 12'h006;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PC2AR,
    ST_AR2MAR,
    ST_IREAD,
    ST_IWAIT,
    ST_DECODE,
    ST_BRANCH,
    ST_OMAR,
    ST_OREAD,
    ST_OWAIT,
    ST_EXEC,
    ST_HALT
  } seq_state_e;
endpackage

// File: rtl/acm_mem.sv
module acm_mem #(
  parameter int WORD_W = 36,
  parameter int AW     = 6,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic              rvalid,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              vld [LAT];
  logic [WORD_W-1:0] dq  [LAT];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < LAT; g++) begin : g_pipe
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld[0] <= 1'b0;
        else        vld[0] <= re & ~we;
      end
      always_ff @(posedge clk) begin
        if (re) dq[0] <= mem[raddr];
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld[g] <= 1'b0;
        else        vld[g] <= vld[g-1];
      end
      always_ff @(posedge clk) begin
        if (vld[g-1]) dq[g] <= dq[g-1];
      end
    end
  end

  assign rvalid = vld[LAT-1];
  assign rdata  = dq[LAT-1];
endmodule

// File: rtl/acm_smadd.sv
module acm_smadd #(
  parameter int WORD_W = 36
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] sum,
  output logic              ovf
);
  localparam int MW = WORD_W - 1;

  logic          sa, sb, so;
  logic [MW-1:0] ma, mb, mo;
  logic [MW:0]   wide;

  always_comb begin
    sa   = a[WORD_W-1];
    sb   = b[WORD_W-1];
    ma   = a[MW-1:0];
    mb   = b[MW-1:0];
    ovf  = 1'b0;
    wide = '0;
    if (sa == sb) begin
      wide = {1'b0, ma} + {1'b0, mb};
      mo   = wide[MW-1:0];
      ovf  = wide[MW];
      so   = sa;
    end else if (ma >= mb) begin
      mo = ma - mb;
      so = (mo == '0) ? 1'b0 : sa;
    end else begin
      mo = mb - ma;
      so = sb;
    end
    sum = {so, mo};
  end
endmodule

// File: rtl/acm_seq.sv
module acm_seq
  import acm_pkg::*;
#(
  parameter int WORD_W  = 36,
  parameter int OPC_W   = 12,
  parameter int FLD_W   = 15,
  parameter int MEM_AW  = 6,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chan_busy,
  input  logic              ld_we,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic [WORD_W-1:0] acc_o,
  output logic [FLD_W-1:0]  pc_o,
  output logic [OPC_W-1:0]  opc_o,
  output logic [FLD_W-1:0]  mar_o,
  output logic              ovf_o,
  output logic              halt_o
);
  localparam int OPC_LSB = WORD_W - OPC_W;

  logic [1:0]        rst_sync;
  logic              rst_q_n;

  seq_state_e        state_q, state_d;
  logic [FLD_W-1:0]  pc_q, pc_d, ar_q, ar_d, mar_q, mar_d;
  logic [WORD_W-1:0] sr_q, sr_d, acc_q, acc_d;
  logic [OPC_W-1:0]  pr_q, pr_d;
  logic              ovf_q, ovf_d;

  logic              mem_re, mem_vld;
  logic [WORD_W-1:0] mem_rdata, add_sum;
  logic              add_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  acm_mem #(.WORD_W(WORD_W), .AW(MEM_AW), .LAT(MEM_LAT)) u_mem (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .we     (ld_we),
    .waddr  (ld_addr),
    .wdata  (ld_data),
    .re     (mem_re),
    .raddr  (mar_q[MEM_AW-1:0]),
    .rvalid (mem_vld),
    .rdata  (mem_rdata)
  );

  acm_smadd #(.WORD_W(WORD_W)) u_add (
    .a   (acc_q),
    .b   (sr_q),
    .sum (add_sum),
    .ovf (add_ovf)
  );

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ar_d    = ar_q;
    mar_d   = mar_q;
    sr_d    = sr_q;
    pr_d    = pr_q;
    acc_d   = acc_q;
    ovf_d   = ovf_q;
    mem_re  = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_PC2AR;
      ST_PC2AR: begin
        ar_d    = pc_q;
        state_d = ST_AR2MAR;
      end
      ST_AR2MAR: begin
        mar_d   = ar_q;
        pc_d    = pc_q + 1'b1;
        state_d = ST_IREAD;
      end
      ST_IREAD: begin
        mem_re  = 1'b1;
        state_d = ST_IWAIT;
      end
      ST_IWAIT: if (mem_vld) begin
        sr_d    = mem_rdata;
        pr_d    = mem_rdata[WORD_W-1:OPC_LSB];
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        ar_d = sr_q[FLD_W-1:0];
        if (pr_q == OPC_LDACC) begin
          acc_d   = '0;
          state_d = ST_OMAR;
        end else if (pr_q == OPC_ADD) begin
          state_d = ST_OMAR;
        end else if (pr_q == OPC_BBUSY) begin
          state_d = ST_BRANCH;
        end else begin
          state_d = ST_HALT;
        end
      end
      ST_BRANCH: begin
        if (chan_busy) pc_d = ar_q;
        state_d = ST_PC2AR;
      end
      ST_OMAR: begin
        mar_d   = ar_q;
        state_d = ST_OREAD;
      end
      ST_OREAD: begin
        mem_re  = 1'b1;
        state_d = ST_OWAIT;
      end
      ST_OWAIT: if (mem_vld) begin
        sr_d    = mem_rdata;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        acc_d   = add_sum;
        ovf_d   = ovf_q | add_ovf;
        state_d = ST_PC2AR;
      end
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ar_q    <= '0;
      mar_q   <= '0;
      sr_q    <= '0;
      pr_q    <= '0;
      acc_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ar_q    <= ar_d;
      mar_q   <= mar_d;
      sr_q    <= sr_d;
      pr_q    <= pr_d;
      acc_q   <= acc_d;
      ovf_q   <= ovf_d;
    end
  end

  assign acc_o  = acc_q;
  assign pc_o   = pc_q;
  assign opc_o  = pr_q;
  assign mar_o  = mar_q;
  assign ovf_o  = ovf_q;
  assign halt_o = (state_q == ST_HALT);
endmodule

// File: rtl/acm_seq_chk.sv
module acm_seq_chk
  import acm_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int OPC_W  = 12,
  parameter int FLD_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input seq_state_e        state,
  input logic [FLD_W-1:0]  pc,
  input logic [FLD_W-1:0]  ar,
  input logic [FLD_W-1:0]  mar,
  input logic [OPC_W-1:0]  pr,
  input logic [WORD_W-1:0] acc,
  input logic              ovf,
  input logic              chan_busy
);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_AR2MAR |=> pc == $past(pc) + 1'b1);

  assert_mar_from_ar_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_AR2MAR |=> mar == $past(ar));

  assert_pr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OMAR || state == ST_OREAD || state == ST_OWAIT || state == ST_EXEC)
      |=> $stable(pr));

  assert_ldacc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && pr == OPC_LDACC) |=> acc == '0);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  assert_branch_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRANCH && chan_busy) |=> pc == $past(ar));

  assert_branch_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRANCH && !chan_busy) |=> $stable(pc));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HALT |=> state == ST_HALT && $stable(pc));

  assert_refetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC || state == ST_BRANCH) |=> state == ST_PC2AR);
endmodule

bind acm_seq acm_seq_chk #(.WORD_W(WORD_W), .OPC_W(OPC_W), .FLD_W(FLD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .state     (state_q),
  .pc        (pc_q),
  .ar        (ar_q),
  .mar       (mar_q),
  .pr        (pr_q),
  .acc       (acc_q),
  .ovf       (ovf_q),
  .chan_busy (chan_busy)
);

// File: tb/test_acm_seq.sv
module test_acm_seq;
  localparam int WORD_W = 36;
  localparam int OPC_W  = 12;
  localparam int FLD_W  = 15;
  localparam int MEM_AW = 6;

  localparam logic [11:0] C_LD  = 12'h050;
  localparam logic [11:0] C_ADD = 12'h040;
  localparam logic [11:0] C_BR  = 12'h006;
  localparam logic [11:0] C_STP = 12'hFFF;

  // row: {a, b, expected acc, expected overflow}
  localparam int NV = 7;
  localparam logic [3*WORD_W:0] VEC [NV] = '{
    {36'h000000005, 36'h000000007, 36'h00000000C, 1'b0},
    {36'h000000009, 36'h800000004, 36'h000000005, 1'b0},
    {36'h800000003, 36'h00000000A, 36'h000000007, 1'b0},
    {36'h000000006, 36'h800000006, 36'h000000000, 1'b0},
    {36'h800000008, 36'h800000002, 36'h80000000A, 1'b0},
    {36'h7FFFFFFFF, 36'h000000001, 36'h000000000, 1'b1},
    {36'h012000003, 36'h005000001, 36'h017000004, 1'b0}
  };

  logic clk, rst_n, start, chan_busy, ld_we;
  logic [MEM_AW-1:0] ld_addr;
  logic [WORD_W-1:0] ld_data, acc_o;
  logic [FLD_W-1:0]  pc_o, mar_o;
  logic [OPC_W-1:0]  opc_o;
  logic ovf_o, halt_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic opc_bad;

  acm_seq #(.WORD_W(WORD_W), .OPC_W(OPC_W), .FLD_W(FLD_W), .MEM_AW(MEM_AW)) i_acm_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_busy(chan_busy),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .acc_o(acc_o), .pc_o(pc_o), .opc_o(opc_o), .mar_o(mar_o),
    .ovf_o(ovf_o), .halt_o(halt_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] ins(input logic [11:0] op, input int addr);
    return {op, 9'b0, addr[FLD_W-1:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; ld_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(input int addr, input logic [WORD_W-1:0] data);
    ld_we = 1'b1; ld_addr = addr[MEM_AW-1:0]; ld_data = data;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic go_and_wait(input int limit);
    opc_bad = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < limit && !halt_o; i++) begin
      if (!(opc_o inside {12'h000, C_LD, C_ADD, C_BR, C_STP})) opc_bad = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; chan_busy = 1'b0;
    ld_we = 1'b0; ld_addr = '0; ld_data = '0;

    // R1: reset state and idle until start
    do_reset();
    repeat (20) @(negedge clk);
    chk("R1 acc", acc_o, '0);
    chk("R1 pc", {21'b0, pc_o}, '0);
    chk("R1 opc", {24'b0, opc_o}, '0);
    chk("R1 flags", {34'b0, ovf_o, halt_o}, '0);

    // vector table: load, add, stop
    for (int v = 0; v < NV; v++) begin
      do_reset();
      load(0, ins(C_LD, 20));
      load(1, ins(C_ADD, 21));
      load(2, ins(C_STP, 0));
      load(20, VEC[v][3*WORD_W:2*WORD_W+1]);
      load(21, VEC[v][2*WORD_W:WORD_W+1]);
      go_and_wait(500);
      chk($sformatf("R6 R5 acc row %0d", v), acc_o, VEC[v][WORD_W:1]);
      chk($sformatf("R7 ovf row %0d", v), {35'b0, ovf_o}, {35'b0, VEC[v][0]});
      chk($sformatf("R2 R10 pc row %0d", v), {21'b0, pc_o}, 36'd3);
      chk($sformatf("R3 R4 opc row %0d", v), {24'b0, opc_o, opc_bad}, {24'b0, C_STP, 1'b0});
    end

    // R7: overflow stays set across a later clean add
    do_reset();
    load(0, ins(C_LD, 20));
    load(1, ins(C_ADD, 21));
    load(2, ins(C_ADD, 22));
    load(3, ins(C_STP, 0));
    load(20, 36'h7FFFFFFFF);
    load(21, 36'h000000002);
    load(22, 36'h000000003);
    go_and_wait(500);
    chk("R7 sticky ovf", {35'b0, ovf_o}, 36'd1);
    chk("R7 truncated then summed acc", acc_o, 36'h000000004);

    // R8: self-loop held by the busy channel
    do_reset();
    load(0, ins(C_BR, 0));
    load(1, ins(C_LD, 20));
    load(2, ins(C_STP, 0));
    load(20, 36'h00000004D);
    chan_busy = 1'b1;
    go_and_wait(300);
    chk("R8 spin no halt", {35'b0, halt_o}, '0);
    chk("R8 spin acc untouched", acc_o, '0);
    chk("R8 spin pc in loop", {35'b0, (pc_o <= 15'd1)}, 36'd1);
    chan_busy = 1'b0;
    go_and_wait(500);
    chk("R8 R10 exit acc", acc_o, 36'h00000004D);
    chk("R8 R10 exit pc", {21'b0, pc_o}, 36'd3);

    // R8: forward jump while busy
    do_reset();
    load(0, ins(C_BR, 5));
    load(1, ins(C_STP, 0));
    load(5, ins(C_LD, 20));
    load(6, ins(C_STP, 0));
    load(20, 36'h800000011);
    chan_busy = 1'b1;
    go_and_wait(500);
    chan_busy = 1'b0;
    chk("R8 taken pc", {21'b0, pc_o}, 36'd7);
    chk("R8 R5 taken acc", acc_o, 36'h800000011);

    // R8: not taken when idle
    do_reset();
    load(0, ins(C_BR, 5));
    load(1, ins(C_STP, 0));
    load(5, ins(C_LD, 20));
    go_and_wait(500);
    chk("R8 fall pc", {21'b0, pc_o}, 36'd2);
    chk("R8 fall acc", acc_o, '0);

    // R9: unknown opcode at address 0, stays halted
    do_reset();
    load(0, ins(12'h123, 9));
    go_and_wait(500);
    chk("R9 halt", {35'b0, halt_o}, 36'd1);
    chk("R9 pc", {21'b0, pc_o}, 36'd1);
    chk("R9 opc", {24'b0, opc_o}, {24'b0, 12'h123});
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 still halted", {35'b0, halt_o}, 36'd1);
    chk("R9 pc frozen", {21'b0, pc_o}, 36'd1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule